// File: doc/BRIEF.md
# Disk Channel Adapter Control/Status Register File

This block holds the local registers of a disk/tape channel adapter and sits between a 16-bit processor register bus and the attached drive. Each access presents a word offset, two byte-lane enables and write data. The low offsets select registers kept inside the block:
- two control words,
- the transfer word count,
- the bus address,
- a diagnostic/status word,
- a data buffer,
- a 6-bit address extension.

Higher offsets pass straight through to the drive's own registers. Every access gets a response one cycle later, carrying read data and an error flag.

The block applies the adapter's access rules. Some bits always read as zero and some always read as one. Some fields can be written only under a condition. A single write-one bit clears all the error flags. Several fields have copies that are kept equal across registers. A control-word write delivers the six command bits (function code and go) to the drive. A data-transfer command that arrives while a transfer is still running is refused and flagged as a program error. The busy/ready condition is a two-state controller:
- `ST_READY` is the state with DONE set.
- An accepted transfer command moves it to `ST_XFER`.
- An `evt_done` pulse or a controller clear moves it back to `ST_READY`.
- A refused command leaves it in `ST_XFER`.

Top module: `adp_csr_file`

## Requirements
- R1: After reset the register at offset 0 (CTL1) reads 0x0080, with DONE in bit 7. The register at offset 3 (CTL2) reads 0x00C0. Offsets 1, 2, 4, 5 and 6 read 0x0000, and the `done` output is 1.
- R2: Offsets 0 to 6 are local registers. Offsets from DRV_BASE (8) up to the top of the address space are passed through to the drive: `drv_acc_valid` is driven, `drv_acc_idx` is set to offset−DRV_BASE, and read data is taken from `drv_rdata`. Offset 7 writes nothing, reads 0 and returns `rsp_err`=1.
- R3: Word count (offset 1), bus address (offset 2) and data buffer (offset 4) update only the byte lanes that are enabled: be[0] covers bits 7:0 and be[1] covers bits 15:8. Bit 0 of the bus address always reads 0.
- R4: A CTL1 write with be[0] sends wdata[5:0] on `drv_cmd`, with a one-cycle `drv_cmd_valid`, in the cycle after the write. Bits 5:1 are the function code and bit 0 is go. Any command that is not a data transfer is always sent. `drv_unit` carries CTL2 bits 2:0.
- R5: A data-transfer command is one with go=1 and a function code of 20 (octal 24) or higher. If it is written while DONE=1, it is sent, DONE drops, and CTL2 bits 15:8 clear.
- R6: A data-transfer command written while DONE=0 is not sent. It sets CTL2 bit 10 (program error).
- R7: A one-cycle pulse on `evt_done` sets DONE.
- R8: Writing 1 to CTL1 bit 14 with be[1] clears CTL2 bits 15:8. CTL1 bit 14 (TRE) reads 1 exactly when any CTL2 bit 15:8 is set. CTL1 bit 15 (SC) reads 1 when TRE is set or a diagnostic attention is latched.
- R9: The interrupt-enable bit sits at bit 6 of both CTL1 and CTL3 (offset 6). A write to either register sets both copies.
- R10: CTL1 bits 9:8 always equal bits 1:0 of the address extension (offset 5). A CTL1 be[1] write changes them only while DONE=1.
- R11: The writable CTL2 bits are unit 2:0, address-inhibit 3, parity-test 4, missed-transfer 9 and parity-error 13. Bits 7:6 always read 1. A 0-to-1 write of bit 9 or bit 13 latches the diagnostic attention, which is cleared only by reset or controller clear.
- R12: A CTL2 be[0] write with bit 5 set resets every local register to the R1 values, instead of performing a normal write.
- R13: The address extension and CTL3 ignore writes that enable only be[1]. The extension reads bits 15:6 as 0. CTL3 holds only bit 6 and bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_be | input | 2 | Byte-lane enables (bit 0 = low byte) |
| req_wdata | input | 16 | Write data, lanes in place |
| rsp_valid | output | 1 | Response one cycle after the access |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Unmapped offset |
| drv_acc_valid | output | 1 | Pass-through access to drive register |
| drv_acc_write | output | 1 | Pass-through is a write |
| drv_acc_idx | output | ADDR_W | Drive register index |
| drv_acc_wdata | output | 16 | Pass-through write data |
| drv_rdata | input | 16 | Drive register read data |
| drv_cmd_valid | output | 1 | Command strobe to drive |
| drv_cmd | output | 6 | Function code and go |
| drv_unit | output | 3 | Selected unit |
| evt_done | input | 1 | Transfer completion pulse |
| done | output | 1 | Controller ready (DONE) |

## Verification
The bench builds the block with its defaults: ADDR_W=5 and DRV_BASE=8. This leaves exactly one unmapped offset (7), sitting between the local registers and the drive window. It also makes the top offset (31) the last drive register, so both window edges and the bad-offset reply can be reached in one run. The commands tested include function codes 19 and 20, which fall on either side of the transfer threshold, as well as transfers issued while the controller is ready and while it is busy.

// File: rtl/adp_pkg.sv
package adp_pkg;
    localparam int DW       = 16;
    localparam int NUM_LOC  = 7;

    localparam int OFS_CTL1 = 0;
    localparam int OFS_WCNT = 1;
    localparam int OFS_BADR = 2;
    localparam int OFS_CTL2 = 3;
    localparam int OFS_DBUF = 4;
    localparam int OFS_AEXT = 5;
    localparam int OFS_CTL3 = 6;

    localparam logic [4:0] XFER_FN_MIN = 5'd20;

    localparam int B_IE     = 6;
    localparam int B_TRECLR = 14;
    localparam int B_CLR    = 5;
    localparam int B_MXF    = 9;
    localparam int B_PE     = 13;
    localparam int E_MXF    = 1;
    localparam int E_PGE    = 2;
    localparam int E_PE     = 5;

    typedef enum logic {ST_READY = 1'b0, ST_XFER = 1'b1} ctl_state_t;
endpackage

// File: rtl/adp_decode.sv
module adp_decode #(
    parameter int ADDR_W   = 5,
    parameter int DRV_BASE = 8,
    parameter int NUM_LOC  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_LOC-1:0] sel_loc,
    output logic              sel_drv,
    output logic              sel_bad,
    output logic [ADDR_W-1:0] drv_idx
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(DRV_BASE);

    genvar g;
    generate
        for (g = 0; g < NUM_LOC; g++) begin : g_sel
            assign sel_loc[g] = (addr == ADDR_W'(g));
        end
    endgenerate

    assign sel_drv = (addr >= BASE_V);
    assign sel_bad = ~sel_drv & ~(|sel_loc);
    assign drv_idx = addr - BASE_V;
endmodule

// File: rtl/adp_word_reg.sv
module adp_word_reg #(
    parameter int          W     = 16,
    parameter logic [15:0] ZMASK = 16'h0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [1:0]   be,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam int HALF = W / 2;
    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (clr) begin
            q_r <= '0;
        end else if (wr) begin
            if (be[0]) q_r[HALF-1:0] <= wdata[HALF-1:0];
            if (be[1]) q_r[W-1:HALF] <= wdata[W-1:HALF];
        end
    end

    assign q = q_r & ~ZMASK[W-1:0];
endmodule

// File: rtl/adp_ctl_fsm.sv
module adp_ctl_fsm
    import adp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start_ok,
    input  logic fin,
    output logic done
);
    ctl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (start_ok) state_d = ST_XFER;
            ST_XFER:  if (clr || fin) state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
        if (clr) state_d = ST_READY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_READY: done = 1'b1;
            ST_XFER:  done = 1'b0;
            default:  done = 1'b1;
        endcase
    end
endmodule

// File: rtl/adp_csr_file.sv
module adp_csr_file
    import adp_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DRV_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              drv_acc_valid,
    output logic              drv_acc_write,
    output logic [ADDR_W-1:0] drv_acc_idx,
    output logic [15:0]       drv_acc_wdata,
    input  logic [15:0]       drv_rdata,
    output logic              drv_cmd_valid,
    output logic [5:0]        drv_cmd,
    output logic [2:0]        drv_unit,
    input  logic              evt_done,
    output logic              done
);
    localparam int NWREG = 3;
    localparam int WOFS [NWREG] = '{OFS_WCNT, OFS_BADR, OFS_DBUF};

    logic [NUM_LOC-1:0] sel_loc;
    logic sel_drv, sel_bad;
    logic [ADDR_W-1:0] drv_idx;

    adp_decode #(.ADDR_W(ADDR_W), .DRV_BASE(DRV_BASE), .NUM_LOC(NUM_LOC)) u_dec (
        .addr(req_addr), .sel_loc(sel_loc), .sel_drv(sel_drv),
        .sel_bad(sel_bad), .drv_idx(drv_idx)
    );

    logic wr, rd;
    assign wr = req_valid & req_write;
    assign rd = req_valid & ~req_write;

    logic ctl1_lo_wr, ctl1_hi_wr, ctl2_lo_wr, ctl2_hi_wr, aext_wr, ctl3_wr;
    logic is_xfer, accept, reject, fwd, clr_ctl, tre_clr;

    assign ctl1_lo_wr = wr & sel_loc[OFS_CTL1] & req_be[0];
    assign ctl1_hi_wr = wr & sel_loc[OFS_CTL1] & req_be[1];
    assign clr_ctl    = wr & sel_loc[OFS_CTL2] & req_be[0] & req_wdata[B_CLR];
    assign ctl2_lo_wr = wr & sel_loc[OFS_CTL2] & req_be[0] & ~req_wdata[B_CLR];
    assign ctl2_hi_wr = wr & sel_loc[OFS_CTL2] & req_be[1] & ~clr_ctl;
    assign aext_wr    = wr & sel_loc[OFS_AEXT] & req_be[0];
    assign ctl3_wr    = wr & sel_loc[OFS_CTL3] & req_be[0];

    assign is_xfer = req_wdata[0] & (req_wdata[5:1] >= XFER_FN_MIN);
    assign accept  = ctl1_lo_wr & is_xfer & done;
    assign reject  = ctl1_lo_wr & is_xfer & ~done;
    assign fwd     = ctl1_lo_wr & ~reject;
    assign tre_clr = ctl1_hi_wr & req_wdata[B_TRECLR];

    adp_ctl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr_ctl),
        .start_ok(accept), .fin(evt_done), .done(done)
    );

    // word-wide data registers, one per generate slot
    logic [15:0] wq [NWREG];
    genvar g;
    generate
        for (g = 0; g < NWREG; g++) begin : g_wreg
            localparam logic [15:0] ZM = (WOFS[g] == OFS_BADR) ? 16'h0001 : 16'h0000;
            adp_word_reg #(.W(DW), .ZMASK(ZM)) u_reg (
                .clk(clk), .rst_n(rst_n), .clr(clr_ctl),
                .wr(wr & sel_loc[WOFS[g]]), .be(req_be),
                .wdata(req_wdata), .q(wq[g])
            );
        end
    endgenerate

    logic [7:0] err_q, err_d;
    logic       sc_q, sc_d;
    logic [5:0] aext_q, aext_d;
    logic       ie_q, ie_d;
    logic [3:0] ipck_q, ipck_d;
    logic [4:0] c2_q, c2_d;

    always_comb begin
        err_d  = err_q;
        sc_d   = sc_q;
        aext_d = aext_q;
        ie_d   = ie_q;
        ipck_d = ipck_q;
        c2_d   = c2_q;
        if (tre_clr || accept) err_d = '0;
        if (ctl2_hi_wr) begin
            if (req_wdata[B_MXF] && !err_q[E_MXF]) sc_d = 1'b1;
            if (req_wdata[B_PE]  && !err_q[E_PE])  sc_d = 1'b1;
            err_d[E_MXF] = req_wdata[B_MXF];
            err_d[E_PE]  = req_wdata[B_PE];
        end
        if (reject) err_d[E_PGE] = 1'b1;
        if (ctl2_lo_wr) c2_d = req_wdata[4:0];
        if (aext_wr) aext_d = req_wdata[5:0];
        if (ctl1_hi_wr && done) aext_d[1:0] = req_wdata[9:8];
        if (ctl1_lo_wr || ctl3_wr) ie_d = req_wdata[B_IE];
        if (ctl3_wr) ipck_d = req_wdata[3:0];
        if (clr_ctl) begin
            err_d = '0; sc_d = 1'b0; aext_d = '0;
            ie_d = 1'b0; ipck_d = '0; c2_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0; sc_q <= 1'b0; aext_q <= '0;
            ie_q <= 1'b0; ipck_q <= '0; c2_q <= '0;
            drv_cmd_valid <= 1'b0; drv_cmd <= '0;
        end else begin
            err_q <= err_d; sc_q <= sc_d; aext_q <= aext_d;
            ie_q <= ie_d; ipck_q <= ipck_d; c2_q <= c2_d;
            drv_cmd_valid <= fwd;
            if (fwd) drv_cmd <= req_wdata[5:0];
        end
    end

    logic tre, sc;
    assign tre = |err_q;
    assign sc  = tre | sc_q;

    logic [15:0] rmux;
    always_comb begin
        rmux = '0;
        if (sel_drv) rmux = drv_rdata;
        else if (sel_loc[OFS_CTL1]) rmux = {sc, tre, 4'b0, aext_q[1:0], done, ie_q, 6'b0};
        else if (sel_loc[OFS_WCNT]) rmux = wq[0];
        else if (sel_loc[OFS_BADR]) rmux = wq[1];
        else if (sel_loc[OFS_CTL2]) rmux = {err_q, 2'b11, 1'b0, c2_q};
        else if (sel_loc[OFS_DBUF]) rmux = wq[2];
        else if (sel_loc[OFS_AEXT]) rmux = {10'b0, aext_q};
        else if (sel_loc[OFS_CTL3]) rmux = {9'b0, ie_q, 2'b0, ipck_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & sel_bad;
            rsp_rdata <= (rd && !sel_bad) ? rmux : 16'h0000;
        end
    end

    assign drv_acc_valid = req_valid & sel_drv;
    assign drv_acc_write = req_write;
    assign drv_acc_idx   = drv_idx;
    assign drv_acc_wdata = req_wdata;
    assign drv_unit      = c2_q[2:0];
endmodule

// File: rtl/adp_csr_file_chk.sv
module adp_csr_file_chk #(
    parameter int ADDR_W   = 5,
    parameter int DRV_BASE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_be,
    input logic [15:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              drv_cmd_valid,
    input logic              evt_done,
    input logic              done
);
    logic xcmd;
    assign xcmd = req_valid && req_write && (req_addr == '0) && req_be[0]
                  && req_wdata[0] && (req_wdata[5:1] >= 5'd20);

    assert_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= ADDR_W'(7) && req_addr < ADDR_W'(DRV_BASE)) |=> rsp_err);

    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xcmd && done) |=> (drv_cmd_valid && !done));

    assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xcmd && !done) |=> !drv_cmd_valid);

    assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> drv_cmd_valid);

    assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !done) |=> done);
endmodule

bind adp_csr_file adp_csr_file_chk #(.ADDR_W(ADDR_W), .DRV_BASE(DRV_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .drv_cmd_valid(drv_cmd_valid),
    .evt_done(evt_done), .done(done)
);

// File: tb/adp_csr_file_tb.sv
module adp_csr_file_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic [1:0] req_be = '0;
    logic [15:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic drv_acc_valid, drv_acc_write;
    logic [4:0] drv_acc_idx;
    logic [15:0] drv_acc_wdata;
    logic [15:0] drv_rdata = 16'h1357;
    logic drv_cmd_valid;
    logic [5:0] drv_cmd;
    logic [2:0] drv_unit;
    logic evt_done = 1'b0;
    logic done;

    int n_chk = 0, n_err = 0;
    logic cap_av, cap_aw;
    logic [4:0] cap_ai;
    logic [15:0] cap_ad;

    always #4 clk = ~clk;

    adp_csr_file u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .drv_acc_valid(drv_acc_valid), .drv_acc_write(drv_acc_write),
        .drv_acc_idx(drv_acc_idx), .drv_acc_wdata(drv_acc_wdata),
        .drv_rdata(drv_rdata), .drv_cmd_valid(drv_cmd_valid), .drv_cmd(drv_cmd),
        .drv_unit(drv_unit), .evt_done(evt_done), .done(done)
    );

    // {rq[3:0], write, addr[4:0], be[1:0], wdata[15:0], expect[15:0], err}
    localparam int NV = 30;
    localparam logic [44:0] VEC [NV] = '{
        {4'd1, 1'b0, 5'd0, 2'b11, 16'h0, 16'h0080, 1'b0},   // R1
        {4'd1, 1'b0, 5'd3, 2'b11, 16'h0, 16'h00C0, 1'b0},   // R1
        {4'd1, 1'b0, 5'd1, 2'b11, 16'h0, 16'h0000, 1'b0},   // R1
        {4'd3, 1'b1, 5'd1, 2'b11, 16'h1234, 16'h0, 1'b0},
        {4'd3, 1'b0, 5'd1, 2'b11, 16'h0, 16'h1234, 1'b0},   // R3
        {4'd3, 1'b1, 5'd1, 2'b10, 16'hAB00, 16'h0, 1'b0},
        {4'd3, 1'b0, 5'd1, 2'b11, 16'h0, 16'hAB34, 1'b0},   // R3
        {4'd3, 1'b1, 5'd2, 2'b01, 16'h00FF, 16'h0, 1'b0},
        {4'd3, 1'b0, 5'd2, 2'b11, 16'h0, 16'h00FE, 1'b0},   // R3
        {4'd3, 1'b1, 5'd4, 2'b11, 16'hBEEF, 16'h0, 1'b0},
        {4'd3, 1'b1, 5'd4, 2'b01, 16'h0011, 16'h0, 1'b0},
        {4'd3, 1'b0, 5'd4, 2'b11, 16'h0, 16'hBE11, 1'b0},   // R3
        {4'd2, 1'b0, 5'd7, 2'b11, 16'h0, 16'h0000, 1'b1},   // R2
        {4'd10, 1'b1, 5'd5, 2'b11, 16'h003F, 16'h0, 1'b0},
        {4'd10, 1'b0, 5'd5, 2'b11, 16'h0, 16'h003F, 1'b0},  // R10
        {4'd10, 1'b0, 5'd0, 2'b11, 16'h0, 16'h0380, 1'b0},  // R10
        {4'd13, 1'b1, 5'd5, 2'b10, 16'hFF00, 16'h0, 1'b0},
        {4'd13, 1'b0, 5'd5, 2'b11, 16'h0, 16'h003F, 1'b0},  // R13
        {4'd10, 1'b1, 5'd0, 2'b10, 16'h0100, 16'h0, 1'b0},
        {4'd10, 1'b0, 5'd5, 2'b11, 16'h0, 16'h003D, 1'b0},  // R10
        {4'd10, 1'b0, 5'd0, 2'b11, 16'h0, 16'h0180, 1'b0},  // R10
        {4'd9, 1'b1, 5'd6, 2'b01, 16'h0045, 16'h0, 1'b0},
        {4'd9, 1'b0, 5'd0, 2'b11, 16'h0, 16'h01C0, 1'b0},   // R9
        {4'd9, 1'b0, 5'd6, 2'b11, 16'h0, 16'h0045, 1'b0},   // R9
        {4'd9, 1'b1, 5'd0, 2'b01, 16'h0000, 16'h0, 1'b0},
        {4'd9, 1'b0, 5'd6, 2'b11, 16'h0, 16'h0005, 1'b0},   // R9
        {4'd13, 1'b1, 5'd6, 2'b10, 16'hFF00, 16'h0, 1'b0},
        {4'd13, 1'b0, 5'd6, 2'b11, 16'h0, 16'h0005, 1'b0},  // R13
        {4'd11, 1'b1, 5'd3, 2'b11, 16'h0007, 16'h0, 1'b0},
        {4'd11, 1'b0, 5'd3, 2'b11, 16'h0, 16'h00C7, 1'b0}   // R11
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [1:0] be,
                       input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        #1;
        cap_av = drv_acc_valid; cap_aw = drv_acc_write;
        cap_ai = drv_acc_idx;   cap_ad = drv_acc_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [4:0] a, input logic [15:0] exp);
        acc(1'b0, a, 2'b11, 16'h0);
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done after reset", {15'b0, done}, 16'h1);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][40], VEC[i][39:35], VEC[i][34:33], VEC[i][32:17]);
            if (!VEC[i][40]) begin
                n_chk++;
                if (rsp_rdata !== VEC[i][16:1] || rsp_err !== VEC[i][0] || !rsp_valid) begin
                    n_err++;
                    $display("FAIL R%0d vec %0d actual=%h/%b expected=%h/%b", VEC[i][44:41], i,
                             rsp_rdata, rsp_err, VEC[i][16:1], VEC[i][0]);
                end
            end
        end

        // R5: accepted transfer (fn 28, go)
        acc(1'b1, 5'd0, 2'b01, 16'h0039);
        chk("R5 cmd strobe", {15'b0, drv_cmd_valid}, 16'h1);
        chk("R5 cmd bits", {10'b0, drv_cmd}, 16'h0039);
        chk("R4 unit", {13'b0, drv_unit}, 16'h7);
        chk("R5 done low", {15'b0, done}, 16'h0);
        rchk("R5 ctl1 busy", 5'd0, 16'h0100);
        // R6: transfer at fn 20 while busy is refused
        acc(1'b1, 5'd0, 2'b01, 16'h0029);
        chk("R6 no strobe", {15'b0, drv_cmd_valid}, 16'h0);
        rchk("R6 pge set", 5'd3, 16'h04C7);
        rchk("R8 tre/sc", 5'd0, 16'hC100);
        // R4: fn 19 is not a transfer, sent even while busy
        acc(1'b1, 5'd0, 2'b01, 16'h0027);
        chk("R4 strobe", {15'b0, drv_cmd_valid}, 16'h1);
        chk("R4 cmd", {10'b0, drv_cmd}, 16'h0027);
        // R10: extension bits locked while busy
        acc(1'b1, 5'd0, 2'b10, 16'h0300);
        rchk("R10 locked", 5'd5, 16'h003D);
        // R7
        @(negedge clk); evt_done = 1'b1;
        @(negedge clk); evt_done = 1'b0;
        chk("R7 done", {15'b0, done}, 16'h1);
        rchk("R7 ctl1", 5'd0, 16'hC180);
        // R8 error clear
        acc(1'b1, 5'd0, 2'b10, 16'h4100);
        rchk("R8 ctl2", 5'd3, 16'h00C7);
        rchk("R8 ctl1", 5'd0, 16'h0180);
        // R11 diagnostic parity bit
        acc(1'b1, 5'd3, 2'b10, 16'h2000);
        rchk("R11 ctl2", 5'd3, 16'h20C7);
        rchk("R11 sc", 5'd0, 16'hC180);
        acc(1'b1, 5'd0, 2'b10, 16'h4100);
        rchk("R11 sc kept", 5'd0, 16'h8180);
        acc(1'b1, 5'd3, 2'b10, 16'h0200);
        rchk("R11 mxf", 5'd3, 16'h02C7);
        // R5 accepted transfer (fn 24) clears errors
        acc(1'b1, 5'd0, 2'b01, 16'h0031);
        chk("R5 cmd2", {10'b0, drv_cmd}, 16'h0031);
        rchk("R5 errs cleared", 5'd3, 16'h00C7);
        rchk("R5 ctl1", 5'd0, 16'h8100);
        // R12 controller clear
        acc(1'b1, 5'd3, 2'b01, 16'h0020);
        chk("R12 done", {15'b0, done}, 16'h1);
        rchk("R12 ctl1", 5'd0, 16'h0080);
        rchk("R12 ctl2", 5'd3, 16'h00C0);
        rchk("R12 wcnt", 5'd1, 16'h0000);
        rchk("R12 aext", 5'd5, 16'h0000);
        // R2 pass-through window
        acc(1'b1, 5'd9, 2'b11, 16'h5A5A);
        chk("R2 acc valid", {15'b0, cap_av}, 16'h1);
        chk("R2 acc write", {15'b0, cap_aw}, 16'h1);
        chk("R2 acc idx", {11'b0, cap_ai}, 16'h0001);
        chk("R2 acc data", cap_ad, 16'h5A5A);
        rchk("R2 drv read", 5'd31, 16'h1357);
        chk("R2 top idx", {11'b0, cap_ai}, 16'h0017);
        chk("R2 no err", {15'b0, rsp_err}, 16'h0);

        finish_run();
    end
endmodule